// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Sequencer

This block sits between a core and a 32-bit external bus. It takes one logical transfer at a time: a byte, a word or a doubleword at any byte address. It breaks that transfer into the physical bus cycles needed to complete it. For each cycle it drives a dword address, four active-low byte enables, a direction flag and the write data lanes. A slave that cannot take the full 32 bits can say so on every cycle by pulling a narrow-port input low. The block then re-runs the upper half of that cycle on the low lanes. Read bytes are gathered into a staging buffer and returned right-justified when the transfer ends.

The request side is a valid/ready stream. `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The request fields only need to be valid in that cycle. A core that holds `req_valid` high simply waits: it is back-pressured for the whole transfer. Completion is a one-clock `done` pulse, which cannot be stalled. `rdata` holds its value until the next request is accepted.

Top module: `bus_size_seq`

## Requirements
- R1: After reset `req_ready` is high. A request is accepted on a rising edge with `req_valid` and `req_ready` both high, and `req_ready` stays low until the transfer ends. `req_size` encodes 0 = byte, 1 = word, 2 or 3 = doubleword. `done` is high for exactly the one clock after the edge that completes the last bus cycle, and `req_ready` is high in that clock.
- R2: Byte enable bit i selects data bits 8i+7..8i, and the lane is active when the bit is 0. During a bus cycle the active lanes form one contiguous run that is never empty. `bus_addr` carries byte-address bits AW-1..2. In idle, all four enables are 1 and `bus_wr` is 0.
- R3: Each bus cycle opens with one clock in which `bus_start` is 1. `bus_rdy_n` is then sampled on every later rising edge. Each high sample adds one wait state, during which address, enables and data are held.
- R4: A transfer whose bytes cross a dword boundary takes one cycle per dword. The higher dword goes first.
- R5: When a cycle enables only lanes 0 and 1, the narrow-port input has no effect and the cycle completes in one go.
- R6: On a read cycle that enables only lanes 2 and 3 and completes with the narrow-port input low, those bytes are taken from data bits 15..0. Bits 31..16 are ignored.
- R7: When a cycle enables lanes from both halves and completes with the narrow-port input low, only its lanes 0 and 1 count. One further cycle follows at the same address with the same upper enables and with enables 0 and 1 negated. The lower half always goes before the upper half.
- R8: In any write cycle whose enables 0 and 1 are both negated, bits 15..0 of `bus_wdata` equal bits 31..16.
- R9: At completion `rdata` holds operand byte k in bits 8k+7..8k. Bytes beyond the operand size read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Byte address of the operand |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, byte 0 in bits 7..0 |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read operand |
| bus_start | output | 1 | First state of a bus cycle |
| bus_addr | output | AW-2 | Dword address of the cycle |
| bus_be_n | output | 4 | Active-low byte lane enables |
| bus_wr | output | 1 | Cycle direction, 1 = write |
| bus_wdata | output | 32 | Write data lanes |
| bus_rdata | input | 32 | Read data lanes |
| bus_rdy_n | input | 1 | Slave ready, active low |
| bus_p16_n | input | 1 | Slave is 16 bits wide, active low |

## Verification
The bench sends transfers that cross dword boundaries and transfers that cross from a full-width region into a narrow one. It also sends three-cycle transfers, where one piece is split again by the narrow port. A sequencer that orders the pieces lowest first, or that splits a narrow cycle upper half first, shows up as a mismatch against the expected cycle list. Transfers that touch only the low lanes in the narrow region catch a design that splits them anyway, because the extra cycle overflows the expected list. Upper-only reads and writes in the narrow region expose missing mirroring or missing lane shifting: garbage is then written to, or read from, the slave's byte array. Random wait states catch a wrong cycle count through the measured latency.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_DATA = 2'd2
  } sq_state_t;

  // lanes touched by an operand, over two adjacent dwords
  function automatic logic [7:0] span_mask(input logic [1:0] off, input logic [1:0] sz);
    logic [7:0] base;
    case (sz)
      2'd0:    base = 8'b0000_0001;
      2'd1:    base = 8'b0000_0011;
      default: base = 8'b0000_1111;
    endcase
    return base << off;
  endfunction

  // one unbroken, non-empty run of lanes
  function automatic logic run_ok(input logic [3:0] m);
    return m inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                     4'b0011, 4'b0110, 4'b1100,
                     4'b0111, 4'b1110, 4'b1111};
  endfunction

endpackage

// File: rtl/bsz_piece_plan.sv
module bsz_piece_plan
  import bsz_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [1:0]       off,
  input  logic [1:0]       size,
  output logic             two_pc,
  output logic [LANES-1:0] m_first,
  output logic [LANES-1:0] m_second
);
  logic [2*LANES-1:0] span;

  always_comb begin
    span     = span_mask(off, size);
    two_pc   = |span[2*LANES-1:LANES];
    // the higher dword runs first when the operand crosses a boundary
    m_first  = two_pc ? span[2*LANES-1:LANES] : span[LANES-1:0];
    m_second = span[LANES-1:0];
  end

endmodule

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer #(
  parameter int LANES = 4,
  parameter int BW    = 8
) (
  input  logic [LANES-1:0]    cyc_m,
  input  logic                p16,
  input  logic [LANES*BW-1:0] src_w,
  input  logic [LANES*BW-1:0] bus_rd,
  input  logic [LANES*BW-1:0] old_slot,
  output logic [LANES*BW-1:0] bus_wd,
  output logic [LANES*BW-1:0] new_slot
);
  localparam int HALF = LANES / 2;

  logic has_lo;
  assign has_lo = |cyc_m[HALF-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < HALF) begin : g_low
      // low lanes carry the upper bytes whenever only the upper half is enabled
      assign bus_wd[i*BW +: BW]   = has_lo ? src_w[i*BW +: BW] : src_w[(i+HALF)*BW +: BW];
      assign new_slot[i*BW +: BW] = cyc_m[i] ? bus_rd[i*BW +: BW] : old_slot[i*BW +: BW];
    end else begin : g_high
      logic take;
      logic [BW-1:0] val;
      assign take = cyc_m[i] && !(p16 && has_lo);
      assign val  = p16 ? bus_rd[(i-HALF)*BW +: BW] : bus_rd[i*BW +: BW];
      assign bus_wd[i*BW +: BW]   = src_w[i*BW +: BW];
      assign new_slot[i*BW +: BW] = take ? val : old_slot[i*BW +: BW];
    end
  end

endmodule

// File: rtl/bus_size_seq.sv
module bus_size_seq
  import bsz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          bus_start,
  output logic [AW-3:0] bus_addr,
  output logic [3:0]    bus_be_n,
  output logic          bus_wr,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_rdy_n,
  input  logic          bus_p16_n
);
  localparam int LANES = 4;
  localparam int BW    = 8;
  localparam int DBW   = LANES * BW;
  localparam int DWA   = AW - 2;
  localparam int HALF  = LANES / 2;

  sq_state_t        state_q;
  logic [1:0]       off_q;
  logic             wr_q;
  logic [2*DBW-1:0] wbuf_q;
  logic [2*DBW-1:0] rbuf_q;
  logic [DWA-1:0]   base_q;
  logic             two_q;
  logic             on_hi_q;
  logic [LANES-1:0] m2_q;
  logic [LANES-1:0] cyc_m_q;
  logic             done_q;

  logic             pl_two;
  logic [LANES-1:0] pl_first;
  logic [LANES-1:0] pl_second;
  logic [DBW-1:0]   src_w;
  logic [DBW-1:0]   old_slot;
  logic [DBW-1:0]   steer_wd;
  logic [DBW-1:0]   new_slot;
  logic             active;
  logic             fin;
  logic             p16;
  logic             split_now;
  logic [2*DBW-1:0] rsh;

  bsz_piece_plan #(.LANES(LANES)) u_plan (
    .off      (req_addr[1:0]),
    .size     (req_size),
    .two_pc   (pl_two),
    .m_first  (pl_first),
    .m_second (pl_second)
  );

  assign src_w    = on_hi_q ? wbuf_q[2*DBW-1:DBW] : wbuf_q[DBW-1:0];
  assign old_slot = on_hi_q ? rbuf_q[2*DBW-1:DBW] : rbuf_q[DBW-1:0];
  assign p16      = !bus_p16_n;

  bsz_lane_steer #(.LANES(LANES), .BW(BW)) u_steer (
    .cyc_m    (cyc_m_q),
    .p16      (p16),
    .src_w    (src_w),
    .bus_rd   (bus_rdata),
    .old_slot (old_slot),
    .bus_wd   (steer_wd),
    .new_slot (new_slot)
  );

  assign active    = (state_q != SQ_IDLE);
  assign fin       = (state_q == SQ_DATA) && !bus_rdy_n;
  assign split_now = fin && p16 && (|cyc_m_q[HALF-1:0]) && (|cyc_m_q[LANES-1:HALF]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      off_q   <= '0;
      wr_q    <= 1'b0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      base_q  <= '0;
      two_q   <= 1'b0;
      on_hi_q <= 1'b0;
      m2_q    <= '0;
      cyc_m_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (req_valid) begin
            off_q   <= req_addr[1:0];
            wr_q    <= req_write;
            wbuf_q  <= {{DBW{1'b0}}, req_wdata} << {req_addr[1:0], 3'b000};
            rbuf_q  <= '0;
            base_q  <= req_addr[AW-1:2];
            two_q   <= pl_two;
            on_hi_q <= pl_two;
            m2_q    <= pl_second;
            cyc_m_q <= pl_first;
            state_q <= SQ_ADDR;
          end
        end
        SQ_ADDR: state_q <= SQ_DATA;
        SQ_DATA: begin
          if (fin) begin
            if (!wr_q) begin
              if (on_hi_q) rbuf_q[2*DBW-1:DBW] <= new_slot;
              else         rbuf_q[DBW-1:0]     <= new_slot;
            end
            if (split_now) begin
              cyc_m_q <= cyc_m_q & {{HALF{1'b1}}, {HALF{1'b0}}};
              state_q <= SQ_ADDR;
            end else if (two_q && on_hi_q) begin
              on_hi_q <= 1'b0;
              cyc_m_q <= m2_q;
              state_q <= SQ_ADDR;
            end else begin
              state_q <= SQ_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign rsh       = rbuf_q >> {off_q, 3'b000};
  assign rdata     = rsh[DBW-1:0];
  assign done      = done_q;
  assign req_ready = (state_q == SQ_IDLE);
  assign bus_start = (state_q == SQ_ADDR);
  assign bus_addr  = base_q + {{(DWA-1){1'b0}}, on_hi_q};
  assign bus_be_n  = active ? ~cyc_m_q : {LANES{1'b1}};
  assign bus_wr    = active && wr_q;
  assign bus_wdata = (active && wr_q) ? steer_wd : '0;

  // R2: lanes of every cycle form one run
  a_r2_contig_run: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || state_q == SQ_DATA) |-> run_ok(~bus_be_n));

  // R3: opening state lasts one clock and is followed by a data state
  a_r3_two_states: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (!bus_start && bus_be_n != 4'hF));

  // R3: a wait state holds address and enables
  a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DATA && bus_rdy_n) |=> ($stable(bus_addr) && $stable(bus_be_n) && !bus_start));

  // R7: narrow split re-runs the upper half at the same address
  a_r7_upper_rerun: assert property (@(posedge clk) disable iff (!rst_n)
    split_now |=> (bus_start && bus_be_n[1:0] == 2'b11 && $stable(bus_addr)));

  // R5: a low-only cycle is never repeated at the same address
  a_r5_low_only_once: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && bus_be_n[3:2] == 2'b11) |=> (!bus_start || bus_addr != $past(bus_addr)));

  // R8: upper-only writes mirror onto the low lanes
  a_r8_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be_n[1:0] == 2'b11) |-> (bus_wdata[15:0] == bus_wdata[31:16]));

  // R1: completion coincides with readiness for the next request
  a_r1_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && bus_be_n == 4'hF));

endmodule

// File: tb/bus_size_seq_tb.sv
module bus_size_seq_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          req_write;
  logic [31:0]   req_wdata;
  logic          done;
  logic [31:0]   rdata;
  logic          bus_start;
  logic [AW-3:0] bus_addr;
  logic [3:0]    bus_be_n;
  logic          bus_wr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          bus_rdy_n;
  logic          bus_p16_n;

  always #10 clk = ~clk;

  bus_size_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .done(done), .rdata(rdata),
    .bus_start(bus_start), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy_n(bus_rdy_n), .bus_p16_n(bus_p16_n)
  );

  typedef struct packed {
    logic [29:0] dw;
    logic [3:0]  be_n;
  } cyc_t;

  logic [7:0]  mem  [256];
  logic [7:0]  refm [256];
  cyc_t        expq [$];
  int          n_chk = 0;
  int          n_err = 0;
  int          tot_w;
  int          maxw;
  int          wleft;
  bit          in_data;
  logic [7:0]  cur_addr;
  logic [31:0] cur_data;
  logic [7:0]  junk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // narrow slave occupies byte addresses with bit 7 set
  function automatic bit is16(input logic [29:0] dw);
    return dw[5];
  endfunction

  assign bus_p16_n = !is16(bus_addr);

  always_comb begin
    logic [7:0] b;
    logic a1;
    b  = {bus_addr[5:0], 2'b00};
    a1 = bus_be_n[0] & bus_be_n[1];
    if (is16(bus_addr)) begin
      bus_rdata[7:0]   = mem[8'(b + {6'd0, a1, 1'b0})];
      bus_rdata[15:8]  = mem[8'(b + {6'd0, a1, 1'b1})];
      bus_rdata[31:16] = {junk, ~junk};
    end else begin
      for (int i = 0; i < 4; i++) bus_rdata[i*8 +: 8] = mem[8'(b + 8'(i))];
    end
  end

  // slave and per-cycle comparison against the expected cycle list
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_data) begin
        if (wleft > 0) begin
          bus_rdy_n = 1'b1;
          wleft--;
          tot_w++;
        end else begin
          bus_rdy_n = 1'b0;
          in_data   = 1'b0;
          if (bus_wr) begin
            logic [7:0] b;
            b = {bus_addr[5:0], 2'b00};
            if (is16(bus_addr)) begin
              logic a1;
              a1 = bus_be_n[0] & bus_be_n[1];
              for (int j = 0; j < 2; j++)
                if (!bus_be_n[2*a1 + j]) mem[8'(b + 8'(2*a1 + j))] = bus_wdata[j*8 +: 8];
            end else begin
              for (int i = 0; i < 4; i++)
                if (!bus_be_n[i]) mem[8'(b + 8'(i))] = bus_wdata[i*8 +: 8];
            end
          end
        end
      end else if (bus_start) begin
        cyc_t e;
        if (expq.size() == 0) begin
          chk(1'b0, "R4", "unexpected extra bus cycle", {bus_addr, bus_be_n}, 0);
        end else begin
          e = expq.pop_front();
          chk(bus_addr == e.dw, "R4", "cycle dword address", bus_addr, e.dw);
          if (is16(e.dw) && e.be_n[3:2] == 2'b11)
            chk(bus_be_n == e.be_n, "R5", "low-only enables", bus_be_n, e.be_n);
          else if (is16(e.dw))
            chk(bus_be_n == e.be_n, "R7", "narrow-port enables", bus_be_n, e.be_n);
          else
            chk(bus_be_n == e.be_n, "R2", "cycle enables", bus_be_n, e.be_n);
        end
        if (bus_wr) begin
          for (int i = 0; i < 4; i++) begin
            if (!bus_be_n[i]) begin
              int k;
              k = int'({bus_addr, 2'b00}) + i - int'(cur_addr);
              chk(bus_wdata[i*8 +: 8] == cur_data[k*8 +: 8], "R2", "write lane data",
                  bus_wdata[i*8 +: 8], cur_data[k*8 +: 8]);
            end
          end
          if (bus_be_n[1:0] == 2'b11)
            chk(bus_wdata[15:0] == bus_wdata[31:16], "R8", "upper lanes mirrored low",
                bus_wdata[15:0], bus_wdata[31:16]);
        end
        junk      = 8'($urandom);
        wleft     = int'($urandom_range(0, maxw));
        in_data   = 1'b1;
        bus_rdy_n = 1'b1;
      end
    end
  end

  task automatic push_piece(input logic [29:0] dw, input logic [3:0] pm);
    if (is16(dw) && (|pm[1:0]) && (|pm[3:2])) begin
      expq.push_back({dw, ~pm});
      expq.push_back({dw, ~(pm & 4'b1100)});
    end else begin
      expq.push_back({dw, ~pm});
    end
  endtask

  task automatic xfer(input logic [7:0] addr, input logic [1:0] size, input bit wr,
                      input logic [31:0] data, input string tag);
    int n, ncyc, lat;
    logic [7:0]  m;
    logic [29:0] dw0;
    logic [31:0] exp_r;
    n   = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    m   = 8'(((1 << n) - 1) << addr[1:0]);
    dw0 = {22'd0, addr[7:2]};
    if (|m[7:4]) push_piece(dw0 + 30'd1, m[7:4]);
    push_piece(dw0, m[3:0]);
    ncyc  = expq.size();
    exp_r = '0;
    for (int k = 0; k < n; k++) exp_r[k*8 +: 8] = refm[8'(addr + 8'(k))];
    if (wr) for (int k = 0; k < n; k++) refm[8'(addr + 8'(k))] = data[k*8 +: 8];
    cur_addr = addr;
    cur_data = data;
    tot_w    = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {24'd0, addr};
    req_size  = size;
    req_write = wr;
    req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = $urandom;
    chk(req_ready == 1'b0, "R1", "ready low during transfer", req_ready, 0);
    lat = 0;
    while (!done && lat < 1000) begin
      lat++;
      @(negedge clk);
    end
    chk(lat == 2 * ncyc + tot_w, "R3", "clocks from accept to done", lat, 2 * ncyc + tot_w);
    chk(expq.size() == 0, "R4", "all expected cycles issued", expq.size(), 0);
    chk(req_ready == 1'b1, "R1", "ready with done", req_ready, 1);
    if (!wr) chk(rdata == exp_r, tag, "read operand", rdata, exp_r);
    else begin
      bit same;
      same = 1'b1;
      for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) same = 1'b0;
      chk(same, tag, "slave memory after write", same, 1);
    end
    expq.delete();
    @(negedge clk);
    chk(done == 1'b0, "R1", "done is one clock", done, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_size  = '0;
    req_write = 1'b0;
    req_wdata = '0;
    bus_rdy_n = 1'b1;
    in_data   = 1'b0;
    wleft     = 0;
    junk      = 8'h5A;
    maxw      = 2;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'($urandom);
      refm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
    chk(bus_be_n == 4'hF, "R10", "reset enables", bus_be_n, 4'hF);
    chk(bus_start == 1'b0 && done == 1'b0 && bus_wr == 1'b0, "R10", "reset strobes",
        {bus_start, done, bus_wr}, 0);

    // full-width region
    xfer(8'h10, 2'd2, 1'b1, 32'hA1B2C3D4, "R1");
    xfer(8'h10, 2'd2, 1'b0, 32'h0, "R1");
    xfer(8'h13, 2'd2, 1'b1, 32'h11223344, "R4");
    xfer(8'h13, 2'd2, 1'b0, 32'h0, "R4");
    xfer(8'h1F, 2'd1, 1'b0, 32'h0, "R4");
    xfer(8'h21, 2'd0, 1'b0, 32'h0, "R9");
    xfer(8'h26, 2'd1, 1'b0, 32'h0, "R9");
    xfer(8'h30, 2'd3, 1'b1, 32'hCAFEF00D, "R1");
    xfer(8'h30, 2'd3, 1'b0, 32'h0, "R1");
    // narrow region
    xfer(8'h81, 2'd0, 1'b0, 32'h0, "R5");
    xfer(8'h80, 2'd1, 1'b1, 32'h00005566, "R5");
    xfer(8'h82, 2'd1, 1'b0, 32'h0, "R6");
    xfer(8'h83, 2'd0, 1'b0, 32'h0, "R6");
    xfer(8'h8A, 2'd1, 1'b1, 32'h0000BEEF, "R8");
    xfer(8'h8A, 2'd1, 1'b0, 32'h0, "R6");
    xfer(8'h90, 2'd2, 1'b1, 32'h01020304, "R7");
    xfer(8'h90, 2'd2, 1'b0, 32'h0, "R7");
    xfer(8'h95, 2'd1, 1'b0, 32'h0, "R7");
    xfer(8'h97, 2'd2, 1'b1, 32'h99887766, "R7");
    xfer(8'h97, 2'd2, 1'b0, 32'h0, "R7");
    // boundary between the two regions
    xfer(8'h7E, 2'd2, 1'b1, 32'hDEADBEEF, "R4");
    xfer(8'h7E, 2'd2, 1'b0, 32'h0, "R4");

    maxw = 3;
    for (int t = 0; t < 300; t++)
      xfer(8'($urandom), 2'($urandom), 1'($urandom), $urandom, "R9");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule